// File: doc/BRIEF.md
# Serial Frequency Word Receiver with Power-Down Request

This block takes a 16-bit frequency word for a tone generator over a three-wire serial link: a shift clock, a data line and a latch strobe. Each rising edge of the shift clock moves one data bit into a shift register. The least significant bit is sent first. A falling edge of the strobe copies the shift register into a holding register. This is double buffering: a new word can be shifted in while the generator keeps running on the old one.

The strobe has a second job. If the strobe is high and the shift register holds all zeros, the block requests power-down. The request ends as soon as that condition no longer holds. The serial side runs on the link's own edges. Both results are passed into the generator's system clock domain. The latch event goes through a toggle flag, a two-flop synchronizer and an edge compare, which gives a one-cycle update pulse. That pulse captures the stable holding register into the system-side word. The power-down request goes through its own two-flop synchronizer.

Top module: `freq_word_loader`

## Requirements
- R1: On each rising edge of `ser_clk`, the shift register takes `ser_dat` into bit 15 and moves its other bits one place toward bit 0. After 16 shifts, the first bit sent is bit 0 and the last bit sent is bit 15 of the word.
- R2: A falling edge of `ser_strobe` copies the shift register into the holding register. Within 6 `sys_clk` cycles, `freq_word` equals that value.
- R3: `freq_word` changes only in a cycle in which `word_update` is high. Shifting new bits without a falling strobe edge leaves `freq_word` unchanged. A rising strobe edge also leaves it unchanged.
- R4: Each falling strobe edge gives exactly one `word_update` pulse, one `sys_clk` cycle wide.
- R5: When `ser_strobe` is high and all 16 shift register bits are zero, `pwr_down` goes to 1 within 4 `sys_clk` cycles.
- R6: When `ser_strobe` is high and the shift register holds any nonzero value, `pwr_down` stays 0.
- R7: `pwr_down` returns to 0 within 4 `sys_clk` cycles after the strobe goes low, or after a 1 is shifted into the register.
- R8: While `sys_rst_n` is low, `freq_word` is 0, `word_update` is 0 and `pwr_down` is 0. Reset also clears the shift register and the holding register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Generator system clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ser_clk | input | 1 | Serial shift clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_strobe | input | 1 | Latch strobe; the falling edge transfers the word, and the high level with an all-zero shift register requests power-down |
| freq_word | output | 16 | Frequency word in the system clock domain |
| word_update | output | 1 | One-cycle pulse marking a new `freq_word` |
| pwr_down | output | 1 | Synchronized power-down flag |

## Verification
Two functions can fall on the same strobe edge. When the strobe is held high over an all-zero register, power-down is asserted. The falling edge that follows must then release power-down and also transfer an all-zero word. The bench provokes this by holding the strobe high right after reset, and at the all-zero entry of its vector table, before dropping the strobe. It then checks three things: `freq_word` holds zero, exactly one update pulse was counted, and `pwr_down` has fallen. A separate case shifts a 1 in while the strobe is still high, which ends power-down without any word transfer.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  // Word width of the serial frequency word.
  localparam int WORD_W = 16;
  // Synchronizer depth for every signal crossing into the system domain.
  localparam int SYNC_STAGES = 2;

  typedef logic [WORD_W-1:0] word_t;

  // LSB-first shift: the new bit enters at the top and moves toward bit 0.
  function automatic word_t shift_in(input word_t cur, input logic bit_in);
    return {bit_in, cur[WORD_W-1:1]};
  endfunction

  // Zero-detect used for the power-down request.
  function automatic logic all_zero(input word_t w);
    return (w == '0);
  endfunction
endpackage

// File: rtl/fwl_sync.sv
module fwl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fwl_serial_rx.sv
module fwl_serial_rx
  import fwl_pkg::*;
(
  input  logic  rst_n,
  input  logic  ser_clk,
  input  logic  ser_dat,
  input  logic  ser_strobe,
  output word_t shift_word,
  output word_t hold_word,
  output logic  xfer_toggle,
  output logic  pd_request
);
  // Shift register, advanced on every rising serial clock edge.
  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) shift_word <= '0;
    else        shift_word <= shift_in(shift_word, ser_dat);
  end

  // Holding register and transfer toggle, both updated on the strobe falling edge.
  always_ff @(negedge ser_strobe or negedge rst_n) begin
    if (!rst_n) begin
      hold_word   <= '0;
      xfer_toggle <= 1'b0;
    end else begin
      hold_word   <= shift_word;
      xfer_toggle <= ~xfer_toggle;
    end
  end

  // Level request: strobe high over an all-zero register.
  assign pd_request = ser_strobe & all_zero(shift_word);
endmodule

// File: rtl/fwl_sys_capture.sv
module fwl_sys_capture
  import fwl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  toggle_sync,
  input  word_t hold_word,
  output word_t word_q,
  output logic  update_q,
  output logic  update_event
);
  logic toggle_prev;

  // Edge compare on the synchronized toggle: one event per transfer.
  assign update_event = toggle_sync ^ toggle_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle_prev <= 1'b0;
      word_q      <= '0;
      update_q    <= 1'b0;
    end else begin
      toggle_prev <= toggle_sync;
      update_q    <= update_event;
      if (update_event) word_q <= hold_word;
    end
  end

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |=> !update_q); // R4
  AST_WORD_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q != $past(word_q)) |-> update_q); // R3
endmodule

// File: rtl/freq_word_loader.sv
module freq_word_loader
  import fwl_pkg::*;
(
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_strobe,
  output logic [WORD_W-1:0] freq_word,
  output logic              word_update,
  output logic              pwr_down
);
  word_t shift_word;
  word_t hold_word;
  logic  xfer_toggle;
  logic  pd_request;
  logic  toggle_sync;
  logic  update_event;

  fwl_serial_rx u_rx (
    .rst_n       (sys_rst_n),
    .ser_clk     (ser_clk),
    .ser_dat     (ser_dat),
    .ser_strobe  (ser_strobe),
    .shift_word  (shift_word),
    .hold_word   (hold_word),
    .xfer_toggle (xfer_toggle),
    .pd_request  (pd_request)
  );

  fwl_sync #(.STAGES(SYNC_STAGES)) u_sync_tog (
    .clk     (sys_clk),
    .rst_n   (sys_rst_n),
    .d_async (xfer_toggle),
    .q_sync  (toggle_sync)
  );

  fwl_sync #(.STAGES(SYNC_STAGES)) u_sync_pd (
    .clk     (sys_clk),
    .rst_n   (sys_rst_n),
    .d_async (pd_request),
    .q_sync  (pwr_down)
  );

  fwl_sys_capture u_cap (
    .clk          (sys_clk),
    .rst_n        (sys_rst_n),
    .toggle_sync  (toggle_sync),
    .hold_word    (hold_word),
    .word_q       (freq_word),
    .update_q     (word_update),
    .update_event (update_event)
  );

  AST_UPD_MATCHES_HOLD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    word_update |-> (freq_word == hold_word)); // R2
  AST_PD_RISE_NEEDS_REQ: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(pwr_down) |-> $past(pd_request, SYNC_STAGES)); // R5
  AST_PD_FALL_NEEDS_DROP: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $fell(pwr_down) |-> !$past(pd_request, SYNC_STAGES)); // R7
endmodule

// File: tb/freq_word_loader_tb.sv
module freq_word_loader_tb;
  logic        sys_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_strobe = 1'b0;
  logic [15:0] freq_word;
  logic        word_update;
  logic        pwr_down;

  int checks = 0;
  int failures = 0;
  int upd_cnt = 0;

  always #2 sys_clk = ~sys_clk;

  freq_word_loader u_dut (
    .sys_clk     (sys_clk),
    .sys_rst_n   (sys_rst_n),
    .ser_clk     (ser_clk),
    .ser_dat     (ser_dat),
    .ser_strobe  (ser_strobe),
    .freq_word   (freq_word),
    .word_update (word_update),
    .pwr_down    (pwr_down)
  );

  always @(negedge sys_clk) if (word_update) upd_cnt++;

  // Each entry: {word, expected pwr_down while strobe is held high}.
  localparam logic [16:0] VEC [8] = '{
    {16'h0001, 1'b0}, {16'h8000, 1'b0}, {16'hA5C3, 1'b0}, {16'h0000, 1'b1},
    {16'hFFFF, 1'b0}, {16'h1234, 1'b0}, {16'h0000, 1'b1}, {16'h7FFE, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(posedge sys_clk);
    #1;
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b; #20;
    ser_clk = 1'b1; #20;
    ser_clk = 1'b0; #10;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) shift_bit(w[i]);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    int c0;
    // Reset state (R8)
    wait_sys(5);
    chk("R8 freq_word in reset", freq_word, 0);
    chk("R8 word_update in reset", word_update, 0);
    chk("R8 pwr_down in reset", pwr_down, 0);
    sys_rst_n = 1'b1;
    wait_sys(3);
    // Cleared shift register: strobe high requests power-down (R8, R5)
    ser_strobe = 1'b1;
    wait_sys(5);
    chk("R8 cleared shift reg gives pwr_down", pwr_down, 1);
    c0 = upd_cnt;
    ser_strobe = 1'b0;   // transfer and release on the same edge
    wait_sys(6);
    chk("R7 release on strobe fall", pwr_down, 0);
    chk("R2 zero word after reset", freq_word, 0);
    chk("R4 one pulse for zero transfer", upd_cnt - c0, 1);

    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      prev = freq_word;
      send_word(VEC[v][16:1]);
      wait_sys(6);
      chk("R3 no change without strobe fall", freq_word, prev);
      c0 = upd_cnt;
      ser_strobe = 1'b1;
      wait_sys(5);
      chk(VEC[v][0] ? "R5 pwr_down on zero word" : "R6 no pwr_down on nonzero word",
          pwr_down, VEC[v][0]);
      chk("R3 rising strobe does not transfer", freq_word, prev);
      ser_strobe = 1'b0;
      wait_sys(6);
      chk("R1 R2 word order and transfer", freq_word, VEC[v][16:1]);
      chk("R4 single update pulse", upd_cnt - c0, 1);
      chk("R7 pwr_down low after strobe fall", pwr_down, 0);
      #30;
    end

    // Release by shifting a 1 while the strobe stays high (R7)
    send_word(16'h0000);
    ser_strobe = 1'b1;
    wait_sys(5);
    chk("R5 pwr_down before shift", pwr_down, 1);
    prev = freq_word;
    shift_bit(1'b1);
    wait_sys(5);
    chk("R7 release by nonzero shift", pwr_down, 0);
    chk("R3 no transfer during release", freq_word, prev);
    ser_strobe = 1'b0;
    wait_sys(6);
    chk("R1 single shifted one lands in bit 15", freq_word, 16'h8000);

    // Reset in mid-operation (R8)
    send_word(16'h3C3C);
    ser_strobe = 1'b1; #20; ser_strobe = 1'b0;
    wait_sys(6);
    chk("R2 word before reset", freq_word, 16'h3C3C);
    sys_rst_n = 1'b0;
    wait_sys(2);
    chk("R8 reset clears freq_word", freq_word, 0);
    sys_rst_n = 1'b1;
    wait_sys(3);
    c0 = upd_cnt;
    ser_strobe = 1'b1; #20; ser_strobe = 1'b0;
    wait_sys(6);
    chk("R8 shift reg cleared by reset", freq_word, 0);
    chk("R4 one pulse after reset", upd_cnt - c0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule